// File: doc/BRIEF.md
# Parallel NOR Flash Two-Byte Controller

This block moves one 16-bit value to and from an asynchronous parallel NOR flash through an 8-bit data bus. It runs on a 50 MHz clock and places every strobe edge of the memory (chip enable, output enable, write enable and the lowest address line) by counting whole clock cycles, so each nanosecond limit of the memory becomes a parameter in cycles. The value is split into two bytes that differ only in the lowest address line: the low byte sits at line value 0 and is always handled first.

A read request fetches both bytes and raises a one-cycle load pulse as each byte is taken from the bus. A write request programs both bytes. Each byte gets a program-setup command strobe, then a data strobe, then status reads until the ready bit is set. A final read-array command leaves the memory ready for plain reads. The block only signals when it drives the bus; the pad buffers live outside. A one-cycle done pulse closes every transfer.

Top module: `nor_pair_ctrl`

## Requirements
- R1: After reset and whenever the block is idle, chip enable, output enable and write enable are high (inactive), the bus is not driven, the address line is 0 and busy is 0.
- R2: A read starts with chip enable low, the address line at 0, output enable high and the bus undriven for exactly 4 cycles; output enable then falls.
- R3: On a read, output enable is low for 2 cycles before a capture cycle in which load_pulse is high; the byte on the bus at the end of that cycle is stored. The byte taken with the address line at 0 lands in rd_value[7:0] and the one at line 1 lands in rd_value[15:8]. There are exactly two load pulses per read.
- R4: Between the two read bytes, output enable is high for 2 cycles while the address line becomes 1. When the read ends, all strobes are high, the address line is 0, the bus is undriven and done is high for one cycle.
- R5: Every write strobe holds chip enable and write enable low together for exactly 3 cycles.
- R6: The bus is driven only during a write strobe, one cycle before it and one cycle after it. It is never driven while output enable is low.
- R7: A write issues five strobes in this order: 0x40 at line 0, wr_value[7:0] at line 0, 0x40 at line 1, wr_value[15:8] at line 1, 0xFF. The first four leave the memory holding wr_value.
- R8: After each data strobe, the controller reads the status byte with output enable, using the same 2-cycle wait and one capture cycle. It repeats this until bit 7 reads 1, and no further strobe starts before that.
- R9: Before the strobes for the high byte, the address line is 1 and write enable is high for at least 2 cycles.
- R10: A write ends with the 0xFF read-array strobe and then a one-cycle done pulse. Later reads return the array contents.
- R11: A request arriving while busy is ignored. If rd_req and wr_req arrive in the same idle cycle, the read is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz clock |
| rst_n | input | 1 | synchronous reset, active low |
| rd_req | input | 1 | start a two-byte read (sampled when idle) |
| wr_req | input | 1 | start a two-byte write (sampled when idle) |
| wr_value | input | 16 | value to program, taken with wr_req |
| rd_value | output | 16 | result of the last read |
| load_pulse | output | 1 | high in the cycle a read byte is captured |
| busy | output | 1 | a transfer is in progress |
| done | output | 1 | one-cycle pulse at the end of a transfer |
| mem_ce_n | output | 1 | memory chip enable, active low |
| mem_oe_n | output | 1 | memory output enable, active low |
| mem_we_n | output | 1 | memory write enable, active low |
| mem_a0 | output | 1 | lowest memory address line |
| bus_drive | output | 1 | 1 when the pad should drive bus_out |
| bus_out | output | 8 | byte to drive on the data bus |
| bus_in | input | 8 | byte read from the data bus |

## Verification
The bench uses the default counts: a 4-cycle enable-to-output wait, 2 cycles to data, a 3-cycle write pulse and a 2-cycle byte gap. These short windows let each strobe width and gap be compared cycle for cycle against the exact numbers in the requirements. A flash model in the bench answers with a random number of not-ready status reads per byte. This exercises the poll loop from zero retries up to several, and shows the controller never starts a strobe early. Collision cases cover requests during busy and both requests at once.

// File: rtl/nor_pair_pkg.sv
// Shared types for the two-byte NOR flash controller.
// Assumes: one state register in the top; pin levels decoded from state.
package nor_pair_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RCE, ST_ROE, ST_RCAP, ST_RGAP,
        ST_WSET, ST_WPUL, ST_WHLD, ST_WGAP, ST_WMOV,
        ST_POE, ST_PCAP, ST_PREL, ST_DONE
    } ctl_state_t;

    typedef enum logic [1:0] {
        OP_SETUP, OP_DATA, OP_ARRAY
    } wr_op_t;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drive;
        logic load;
        logic done;
        logic busy;
    } pin_set_t;

endpackage

// File: rtl/nor_step_timer.sv
// Cycle counter that times how long the controller stays in a state.
// Assumes: len >= 1 and is constant while a state lasts; hold keeps it at zero.
module nor_step_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic [TW-1:0] len,
    output logic          expire
);
    logic [TW-1:0] cnt_q;

    assign expire = (cnt_q == len - 1'b1);

    // Count cycles in the present state, restart on expiry or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (hold || expire) cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    p_cnt_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |-> (cnt_q < len));

endmodule

// File: rtl/nor_pin_decode.sv
// Maps the controller state to strobe, drive, load, done and busy levels.
// Assumes: purely combinational; the state is a register, so outputs are clean.
module nor_pin_decode
    import nor_pair_pkg::*;
(
    input  ctl_state_t st,
    output pin_set_t   pins
);
    // Decode the pin levels for each state.
    always_comb begin
        pins = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0,
                 load: 1'b0, done: 1'b0, busy: 1'b1};
        case (st)
            ST_IDLE: pins.busy = 1'b0;
            ST_RCE, ST_RGAP, ST_WGAP, ST_WMOV, ST_PREL: pins.ce_n = 1'b0;
            ST_ROE, ST_POE: begin
                pins.ce_n = 1'b0;
                pins.oe_n = 1'b0;
            end
            ST_RCAP: begin
                pins.ce_n = 1'b0;
                pins.oe_n = 1'b0;
                pins.load = 1'b1;
            end
            ST_PCAP: begin
                pins.ce_n = 1'b0;
                pins.oe_n = 1'b0;
            end
            ST_WSET, ST_WHLD: begin
                pins.ce_n  = 1'b0;
                pins.drive = 1'b1;
            end
            ST_WPUL: begin
                pins.ce_n  = 1'b0;
                pins.we_n  = 1'b0;
                pins.drive = 1'b1;
            end
            ST_DONE: pins.done = 1'b1;
            default: pins.busy = 1'b1;
        endcase
    end

endmodule

// File: rtl/nor_byte_capture.sv
// Assembles the read result one byte at a time from the data bus.
// Assumes: cap_en is high for a single cycle per byte; sel picks the lane.
module nor_byte_capture #(
    parameter int DW = 8,
    parameter int NB = 2,
    localparam int SW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_en,
    input  logic [SW-1:0]   sel,
    input  logic [DW-1:0]   din,
    output logic [NB*DW-1:0] word
);
    for (genvar i = 0; i < NB; i++) begin : g_lane
        // Store the bus byte into lane i when that lane is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)                            word[i*DW +: DW] <= '0;
            else if (cap_en && (sel == SW'(i)))    word[i*DW +: DW] <= din;
        end
    end

endmodule

// File: rtl/nor_pair_ctrl.sv
// Two-byte read/program controller for an asynchronous parallel NOR flash.
// Assumes: 50 MHz clock, all memory timing given as whole cycle counts,
// external pad buffer driven by bus_drive/bus_out, memory status ready on bit RDY_BIT.
module nor_pair_ctrl
    import nor_pair_pkg::*;
#(
    parameter int          DW         = 8,
    parameter int          T_CE_OE    = 4,
    parameter int          T_OE_DATA  = 2,
    parameter int          T_WE_LOW   = 3,
    parameter int          T_BYTE_GAP = 2,
    parameter int          RDY_BIT    = 7,
    parameter logic [7:0]  CMD_PGM    = 8'h40,
    parameter logic [7:0]  CMD_ARRAY  = 8'hFF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_req,
    input  logic            wr_req,
    input  logic [2*DW-1:0] wr_value,
    output logic [2*DW-1:0] rd_value,
    output logic            load_pulse,
    output logic            busy,
    output logic            done,
    output logic            mem_ce_n,
    output logic            mem_oe_n,
    output logic            mem_we_n,
    output logic            mem_a0,
    output logic            bus_drive,
    output logic [DW-1:0]   bus_out,
    input  logic [DW-1:0]   bus_in
);
    localparam int MAX_A  = (T_CE_OE > T_OE_DATA) ? T_CE_OE : T_OE_DATA;
    localparam int MAX_B  = (T_WE_LOW > T_BYTE_GAP) ? T_WE_LOW : T_BYTE_GAP;
    localparam int MAXLEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TW     = $clog2(MAXLEN + 1) + 1;

    ctl_state_t      st_q;
    wr_op_t          op_q;
    logic            sel_q;
    logic            rdy_q;
    logic [2*DW-1:0] wr_hold_q;
    logic [TW-1:0]   len;
    logic            expire;
    pin_set_t        pins;

    // Pick the dwell length in cycles for the present state.
    always_comb begin
        case (st_q)
            ST_RCE:                    len = TW'(T_CE_OE);
            ST_ROE, ST_POE:            len = TW'(T_OE_DATA);
            ST_RGAP, ST_WGAP, ST_WMOV: len = TW'(T_BYTE_GAP);
            ST_WPUL:                   len = TW'(T_WE_LOW);
            default:                   len = TW'(1);
        endcase
    end

    nor_step_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (st_q == ST_IDLE),
        .len    (len),
        .expire (expire)
    );

    nor_pin_decode u_decode (
        .st   (st_q),
        .pins (pins)
    );

    nor_byte_capture #(.DW(DW), .NB(2)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (st_q == ST_RCAP),
        .sel    (sel_q),
        .din    (bus_in),
        .word   (rd_value)
    );

    // Sequence the read, program, poll and read-array steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            op_q      <= OP_SETUP;
            sel_q     <= 1'b0;
            rdy_q     <= 1'b0;
            wr_hold_q <= '0;
        end else if (st_q == ST_IDLE) begin
            sel_q <= 1'b0;
            if (rd_req) begin
                st_q <= ST_RCE;
            end else if (wr_req) begin
                st_q      <= ST_WSET;
                op_q      <= OP_SETUP;
                wr_hold_q <= wr_value;
            end
        end else if (expire) begin
            case (st_q)
                ST_RCE:  st_q <= ST_ROE;
                ST_ROE:  st_q <= ST_RCAP;
                ST_RCAP: st_q <= sel_q ? ST_DONE : ST_RGAP;
                ST_RGAP: st_q <= ST_ROE;
                ST_WSET: st_q <= ST_WPUL;
                ST_WPUL: st_q <= ST_WHLD;
                ST_WHLD: st_q <= ST_WGAP;
                ST_WGAP: begin
                    case (op_q)
                        OP_SETUP: begin
                            op_q <= OP_DATA;
                            st_q <= ST_WSET;
                        end
                        OP_DATA: st_q <= ST_POE;
                        default: st_q <= ST_DONE;
                    endcase
                end
                ST_POE:  st_q <= ST_PCAP;
                ST_PCAP: begin
                    rdy_q <= bus_in[RDY_BIT];
                    st_q  <= ST_PREL;
                end
                ST_PREL: begin
                    if (!rdy_q) begin
                        st_q <= ST_POE;
                    end else if (!sel_q) begin
                        op_q <= OP_SETUP;
                        st_q <= ST_WMOV;
                    end else begin
                        op_q <= OP_ARRAY;
                        st_q <= ST_WSET;
                    end
                end
                ST_WMOV: st_q <= ST_WSET;
                ST_DONE: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
            if ((st_q == ST_RCAP && !sel_q) || (st_q == ST_PREL && rdy_q && !sel_q))
                sel_q <= 1'b1;
        end
    end

    // Choose the byte a write strobe carries.
    always_comb begin
        bus_out = '0;
        if (pins.drive) begin
            case (op_q)
                OP_SETUP: bus_out = CMD_PGM;
                OP_DATA:  bus_out = sel_q ? wr_hold_q[2*DW-1:DW] : wr_hold_q[DW-1:0];
                default:  bus_out = CMD_ARRAY;
            endcase
        end
    end

    assign mem_ce_n   = pins.ce_n;
    assign mem_oe_n   = pins.oe_n;
    assign mem_we_n   = pins.we_n;
    assign bus_drive  = pins.drive;
    assign load_pulse = pins.load;
    assign done       = pins.done;
    assign busy       = pins.busy;
    assign mem_a0     = (st_q == ST_IDLE || st_q == ST_DONE) ? 1'b0 : sel_q;

    // Length of the present write-enable low run, for the width check.
    logic [7:0] we_lo_q;
    always_ff @(posedge clk) begin
        if (!rst_n)         we_lo_q <= '0;
        else if (!mem_we_n) we_lo_q <= we_lo_q + 1'b1;
        else                we_lo_q <= '0;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_ce_n && mem_oe_n && mem_we_n && !bus_drive && !mem_a0));

    p_load_after_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |-> (!mem_oe_n && !$past(mem_oe_n) && !$past(mem_oe_n, 2)));

    p_we_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_lo_q == 8'(T_WE_LOW)));

    p_oe_no_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !bus_drive);

    p_we_with_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (bus_drive && !mem_ce_n));

    p_a0_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_a0));

    p_done_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

// File: tb/nor_pair_ctrl_bench.sv
// Bench for nor_pair_ctrl with a behavioural flash model and protocol monitor.
module nor_pair_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req = 1'b0;
    logic        wr_req = 1'b0;
    logic [15:0] wr_value = '0;
    logic [15:0] rd_value;
    logic        load_pulse, busy, done;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_a0, bus_drive;
    logic [7:0]  bus_out;
    logic [7:0]  bus_in;

    always #10 clk = ~clk;

    nor_pair_ctrl u_nor_pair_ctrl (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
        .wr_value(wr_value), .rd_value(rd_value), .load_pulse(load_pulse),
        .busy(busy), .done(done), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_a0(mem_a0), .bus_drive(bus_drive),
        .bus_out(bus_out), .bus_in(bus_in)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    // flash model state
    logic [7:0] arr [2];
    int  mode = 0;          // 0 array, 1 status
    bit  exp_data = 0;
    int  polls_left = 0;
    int  delay_next = 0;

    assign bus_in = (mode == 1) ? ((polls_left == 0) ? 8'h80 : 8'h00)
                                : arr[mem_a0];

    // monitor state
    int ns, first_oe, ce_cnt, loads, min_oe, oe_run, viol, poll_cnt;
    int done_cnt, dbl, we_run, a0_run, bad_w;
    logic [7:0] log_byte [16];
    logic       log_a0   [16];
    int         log_gap  [16];
    logic [7:0] last_byte;
    logic       last_a0;
    bit pw = 1, po = 1, pd = 0;

    function automatic bit [7:0] lo(input logic [15:0] v); return v[7:0];  endfunction
    function automatic bit [7:0] hi(input logic [15:0] v); return v[15:8]; endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        ns = 0; first_oe = -1; loads = 0; min_oe = 99; viol = 0;
        poll_cnt = 0; done_cnt = 0; dbl = 0; bad_w = 0;
    endtask

    // Observe the pins away from the active edge and run the flash model.
    always @(negedge clk) begin
        if (rst_n) begin
            if (po && !mem_oe_n && first_oe < 0) first_oe = ce_cnt;
            if (mem_ce_n) ce_cnt = 0;
            else if (mem_oe_n) ce_cnt++;
            if (load_pulse) begin
                loads++;
                if (oe_run < min_oe) min_oe = oe_run;
            end
            if (mem_oe_n) oe_run = 0; else oe_run++;
            if (bus_drive && !mem_oe_n) viol++;
            if (mode == 1 && po && !mem_oe_n) poll_cnt++;
            if (mode == 1 && !po && mem_oe_n && polls_left > 0) polls_left--;
            if (!mem_we_n) begin
                if (pw && ns < 16) log_gap[ns] = a0_run;
                we_run++;
                last_byte = bus_out;
                last_a0   = mem_a0;
            end else if (!pw) begin
                if (ns < 16) begin
                    log_byte[ns] = last_byte;
                    log_a0[ns]   = last_a0;
                end
                if (we_run != 3) bad_w++;
                ns++;
                we_run = 0;
                if (exp_data) begin
                    arr[last_a0] = last_byte;
                    exp_data = 0;
                    mode = 1;
                    polls_left = delay_next;
                end else if (last_byte == 8'h40) exp_data = 1;
                else if (last_byte == 8'hFF) mode = 0;
            end
            if (mem_we_n && mem_a0) a0_run++; else a0_run = 0;
            if (done) begin
                done_cnt++;
                if (pd) dbl++;
            end
            pw = mem_we_n; po = mem_oe_n; pd = done;
        end
    end

    task automatic wait_done();
        int n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(n < 2000, "R10", "transfer timeout", n, 0);
        repeat (3) @(negedge clk);
        #1;
    endtask

    task automatic check_idle(input string req);
        chk(mem_ce_n && mem_oe_n && mem_we_n, req, "strobes high",
            {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
        chk(!bus_drive && !mem_a0 && !busy, req, "drive/a0/busy low",
            {bus_drive, mem_a0, busy}, 0);
    endtask

    task automatic do_read();
        logic [15:0] exp_v;
        exp_v = {arr[1], arr[0]};
        clear_mon();
        @(negedge clk) rd_req = 1;
        @(negedge clk) rd_req = 0;
        wait_done();
        chk(first_oe == 4, "R2", "ce low before oe", first_oe, 4);
        chk(loads == 2, "R3", "load pulses", loads, 2);
        chk(min_oe == 2, "R3", "oe cycles before load", min_oe, 2);
        chk(rd_value == exp_v, "R3", "read value", rd_value, exp_v);
        chk(done_cnt == 1 && dbl == 0, "R4", "done pulse", done_cnt, 1);
        check_idle("R4");
        chk(ns == 0, "R4", "no strobes during read", ns, 0);
    endtask

    task automatic do_write(input logic [15:0] v, input int d);
        delay_next = d;
        clear_mon();
        @(negedge clk) begin wr_req = 1; wr_value = v; end
        @(negedge clk) wr_req = 0;
        wait_done();
        chk(ns == 5, "R7", "strobe count", ns, 5);
        chk(bad_w == 0, "R5", "strobe widths not 3", bad_w, 0);
        chk(viol == 0, "R6", "drive while oe low", viol, 0);
        if (ns == 5) begin
            chk(log_byte[0] == 8'h40 && log_a0[0] == 0, "R7", "strobe0", log_byte[0], 8'h40);
            chk(log_byte[1] == lo(v) && log_a0[1] == 0, "R7", "strobe1 low byte", log_byte[1], lo(v));
            chk(log_byte[2] == 8'h40 && log_a0[2] == 1, "R7", "strobe2", log_byte[2], 8'h40);
            chk(log_byte[3] == hi(v) && log_a0[3] == 1, "R7", "strobe3 high byte", log_byte[3], hi(v));
            chk(log_byte[4] == 8'hFF, "R10", "read-array strobe", log_byte[4], 8'hFF);
            chk(log_gap[2] >= 2, "R9", "a0 high we high gap", log_gap[2], 2);
        end
        chk({arr[1], arr[0]} == v, "R7", "memory contents", {arr[1], arr[0]}, v);
        chk(poll_cnt == 2 * (d + 1), "R8", "status polls", poll_cnt, 2 * (d + 1));
        chk(mode == 0, "R10", "memory back in array mode", mode, 0);
        chk(done_cnt == 1 && dbl == 0, "R10", "done pulse", done_cnt, 1);
        check_idle("R1");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned r;
        r = $urandom(32'h5EED);
        arr[0] = 8'h3C; arr[1] = 8'hA5;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        check_idle("R1");
        chk(!done && !load_pulse, "R1", "done/load low after reset", {done, load_pulse}, 0);

        // directed read of preset contents
        do_read();
        // directed writes: no retries and several retries
        do_write(16'h1234, 0);
        do_read();
        do_write(16'hFF00, 3);
        do_read();

        // R11: write request during a busy read is ignored
        clear_mon();
        @(negedge clk) rd_req = 1;
        @(negedge clk) rd_req = 0;
        repeat (3) @(negedge clk);
        wr_req = 1; wr_value = 16'hBEEF;
        @(negedge clk) wr_req = 0;
        wait_done();
        chk(ns == 0, "R11", "strobes after busy request", ns, 0);
        chk(done_cnt == 1, "R11", "single transfer", done_cnt, 1);
        chk({arr[1], arr[0]} == 16'hFF00, "R11", "memory untouched", {arr[1], arr[0]}, 16'hFF00);
        check_idle("R11");

        // R11: simultaneous requests take the read
        clear_mon();
        @(negedge clk) begin rd_req = 1; wr_req = 1; wr_value = 16'h0F0F; end
        @(negedge clk) begin rd_req = 0; wr_req = 0; end
        wait_done();
        chk(ns == 0 && loads == 2, "R11", "read wins", ns, 0);
        chk(rd_value == 16'hFF00, "R11", "read value", rd_value, 16'hFF00);

        // random mix
        for (int i = 0; i < 10; i++) begin
            logic [15:0] v;
            v = 16'($urandom);
            do_write(v, int'($urandom % 5));
            do_read();
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule